// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and drives the command, address, clock-enable and byte-mask pins from reset until the memory is ready for traffic. It waits a programmable number of clock cycles, which stands for the roughly 200 µs settling time a device needs after power is applied. During that wait it keeps clock enable and every byte-mask line high and drives only no-operation commands, so the data bus cannot see contention.

After the wait it precharges both banks at once. It then loads the device mode register with a word taken from its `mode_word` input. Next it issues a train of auto-refresh commands, with a row-cycle gap after each one. Every gap is a count of clock cycles set by a parameter. When the last refresh gap has run out, the block raises `init_done` and releases the byte masks. It then drives no-operation commands until the next reset, and the normal controller takes over the pins from there.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset, and for exactly INIT_WAIT cycles after reset is released, the command is NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) and `init_done` is low.
- R2: `mem_cke` is high in every cycle, and `mem_dqm` is all ones in every cycle in which `init_done` is low.
- R3: In the cycle after the wait, a precharge command (cs_n=0, ras_n=0, cas_n=1, we_n=0) is driven with address bit AP_BIT high, which selects all banks.
- R4: The precharge is followed by exactly TRP NOP cycles and then a mode-register-set command (all four command lines low), with `mem_addr` equal to `mode_word` and `mem_ba` low.
- R5: The mode-register-set is followed by exactly TMRD NOP cycles (TMRD is at least 1) before the next command.
- R6: Auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) are then issued max(NUM_REF, 8) times in a row, each followed by exactly TRC NOP cycles.
- R7: `init_done` rises in the cycle after the last refresh gap ends and stays high until reset. While it is high, only NOP is driven.
- R8: `mem_dqm` goes to all zeros in the same cycle in which `init_done` rises, and not before.
- R9: A reset asserted at any point in the sequence returns the block to the R1 state, and the whole sequence then restarts from the beginning.
- R10: Every command other than NOP is driven for exactly one clock cycle, and a NOP follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_word | input | ADDR_W | Value placed on the address pins during mode-register-set |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 1 | Bank select |
| mem_addr | output | ADDR_W | Address pins |
| mem_dqm | output | DQM_W | Byte masks, high masks the lane |
| init_done | output | 1 | High once initialization is complete |

## Verification
All outputs come from the phase register, so every pin changes one clock edge after the edge that ends the previous step. A result is therefore due a fixed number of cycles after reset release: the precharge comes INIT_WAIT cycles after release, the mode set comes TRP+1 cycles after that, and so on. The bench builds the whole expected pin schedule as a queue indexed by the number of edges since reset release. It compares the pins against that queue at every falling edge, so each check lands half a cycle after the edge that produced the value. A second run aborts the sequence partway and checks that the restart keeps to the same schedule. A second instance with a refresh count below eight checks that the count is raised to eight.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command encoding as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_t;

    typedef enum logic [2:0] {
        PH_WAIT,
        PH_PRE,
        PH_GAP_PRE,
        PH_MRS,
        PH_GAP_MRS,
        PH_REF,
        PH_GAP_REF,
        PH_DONE
    } phase_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int at_least(input int v, input int floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int TRP       = 2,
    parameter int TMRD      = 2,
    parameter int TRC       = 7,
    parameter int REF_TOTAL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zero,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output phase_t           phase
);
    localparam int REF_W = $clog2(REF_TOTAL + 1);

    phase_t           nxt;
    logic [REF_W-1:0] ref_seen;

    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        load_val = '0;
        unique case (phase)
            PH_WAIT:    if (zero) nxt = PH_PRE;
            PH_PRE: begin
                nxt      = PH_GAP_PRE;
                load     = 1'b1;
                load_val = CNT_W'(TRP - 1);
            end
            PH_GAP_PRE: if (zero) nxt = PH_MRS;
            PH_MRS: begin
                nxt      = PH_GAP_MRS;
                load     = 1'b1;
                load_val = CNT_W'(TMRD - 1);
            end
            PH_GAP_MRS: if (zero) nxt = PH_REF;
            PH_REF: begin
                nxt      = PH_GAP_REF;
                load     = 1'b1;
                load_val = CNT_W'(TRC - 1);
            end
            PH_GAP_REF: if (zero) nxt = (ref_seen == REF_W'(REF_TOTAL)) ? PH_DONE : PH_REF;
            PH_DONE:    nxt = PH_DONE;
            default:    nxt = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_WAIT;
            ref_seen <= '0;
        end else begin
            phase <= nxt;
            if (phase == PH_REF)
                ref_seen <= ref_seen + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_init_drv.sv
module sdram_init_drv
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DQM_W  = 4,
    parameter int AP_BIT = 8
) (
    input  phase_t            phase,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DQM_W-1:0]  mem_dqm,
    output logic              init_done
);
    cmd_t cmd;

    always_comb begin
        cmd      = CMD_NOP;
        mem_addr = '0;
        unique case (phase)
            PH_PRE: begin
                cmd              = CMD_PRE;
                mem_addr[AP_BIT] = 1'b1;
            end
            PH_MRS: begin
                cmd      = CMD_MRS;
                mem_addr = mode_word;
            end
            PH_REF:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
    assign init_done = (phase == PH_DONE);
    assign mem_cke   = 1'b1;
    assign mem_ba    = 1'b0;
    assign mem_dqm   = init_done ? '0 : '1;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DQM_W     = 4,
    parameter int AP_BIT    = 8,
    parameter int INIT_WAIT = 20000,
    parameter int TRP       = 3,
    parameter int TMRD      = 2,
    parameter int TRC       = 7,
    parameter int NUM_REF   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DQM_W-1:0]  mem_dqm,
    output logic              init_done
);
    localparam int REF_TOTAL = at_least(NUM_REF, 8);
    localparam int CNT_MAX   = max4(INIT_WAIT, TRP, TMRD, TRC);
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    logic             t_load;
    logic             t_zero;
    logic [CNT_W-1:0] t_val;
    phase_t           phase;

    sdram_init_timer #(
        .CNT_W  (CNT_W),
        .RST_VAL(INIT_WAIT - 1)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .load_val(t_val),
        .zero    (t_zero)
    );

    sdram_init_fsm #(
        .CNT_W    (CNT_W),
        .TRP      (TRP),
        .TMRD     (TMRD),
        .TRC      (TRC),
        .REF_TOTAL(REF_TOTAL)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .zero    (t_zero),
        .load    (t_load),
        .load_val(t_val),
        .phase   (phase)
    );

    sdram_init_drv #(
        .ADDR_W(ADDR_W),
        .DQM_W (DQM_W),
        .AP_BIT(AP_BIT)
    ) u_drv (
        .phase    (phase),
        .mode_word(mode_word),
        .mem_cke  (mem_cke),
        .mem_cs_n (mem_cs_n),
        .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n),
        .mem_we_n (mem_we_n),
        .mem_ba   (mem_ba),
        .mem_addr (mem_addr),
        .mem_dqm  (mem_dqm),
        .init_done(init_done)
    );
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W = 11,
    parameter int DQM_W  = 4,
    parameter int AP_BIT = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_cke,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DQM_W-1:0]  mem_dqm,
    input logic              init_done
);
    logic [3:0] cmd;
    assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    assert_masked_until_done_R2: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (mem_cke && (&mem_dqm)));

    assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> mem_addr[AP_BIT]);

    assert_mrs_then_nop_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |=> (cmd == 4'b0111));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd == 4'b0111));

    assert_dqm_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (mem_dqm == '0));

    assert_one_cycle_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'b0111) |=> (cmd == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W(ADDR_W),
    .DQM_W (DQM_W),
    .AP_BIT(AP_BIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_cke  (mem_cke),
    .mem_cs_n (mem_cs_n),
    .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n),
    .mem_we_n (mem_we_n),
    .mem_addr (mem_addr),
    .mem_dqm  (mem_dqm),
    .init_done(init_done)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 11;
    localparam int DW   = 4;
    localparam int APB  = 8;
    localparam int WAIT = 40;
    localparam int T_RP = 2;
    localparam int T_MD = 2;
    localparam int T_RC = 5;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] mode_word = '0;

    logic cke0, cs0, ras0, cas0, we0, ba0, done0;
    logic [AW-1:0] addr0;
    logic [DW-1:0] dqm0;
    logic cke1, cs1, ras1, cas1, we1, ba1, done1;
    logic [AW-1:0] addr1;
    logic [DW-1:0] dqm1;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic finished = 1'b0;

    logic [3:0] exp_cmd[$];
    string      exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_init_seq #(.ADDR_W(AW), .DQM_W(DW), .AP_BIT(APB), .INIT_WAIT(WAIT),
        .TRP(T_RP), .TMRD(T_MD), .TRC(T_RC), .NUM_REF(8)) u0 (
        .clk(clk), .rst(rst), .mode_word(mode_word),
        .mem_cke(cke0), .mem_cs_n(cs0), .mem_ras_n(ras0), .mem_cas_n(cas0),
        .mem_we_n(we0), .mem_ba(ba0), .mem_addr(addr0), .mem_dqm(dqm0),
        .init_done(done0));

    sdram_init_seq #(.ADDR_W(AW), .DQM_W(DW), .AP_BIT(APB), .INIT_WAIT(WAIT),
        .TRP(T_RP), .TMRD(T_MD), .TRC(T_RC), .NUM_REF(3)) u1 (
        .clk(clk), .rst(rst), .mode_word(mode_word),
        .mem_cke(cke1), .mem_cs_n(cs1), .mem_ras_n(ras1), .mem_cas_n(cas1),
        .mem_we_n(we1), .mem_ba(ba1), .mem_addr(addr1), .mem_dqm(dqm1),
        .init_done(done1));

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic build_model();
        exp_cmd.delete();
        exp_tag.delete();
        for (int i = 0; i < WAIT; i++) begin exp_cmd.push_back(NOP); exp_tag.push_back("R1"); end
        exp_cmd.push_back(PRE); exp_tag.push_back("R3");
        for (int i = 0; i < T_RP; i++) begin exp_cmd.push_back(NOP); exp_tag.push_back("R4"); end
        exp_cmd.push_back(MRS); exp_tag.push_back("R4");
        for (int i = 0; i < T_MD; i++) begin exp_cmd.push_back(NOP); exp_tag.push_back("R5"); end
        for (int r = 0; r < 8; r++) begin
            exp_cmd.push_back(REF); exp_tag.push_back("R6");
            for (int i = 0; i < T_RC; i++) begin exp_cmd.push_back(NOP); exp_tag.push_back("R6"); end
        end
    endtask

    task automatic check_cycle(input int p);
        logic [3:0] act, exp;
        logic       exp_done;
        string      tag;
        act = {cs0, ras0, cas0, we0};
        if (p < exp_cmd.size()) begin
            exp = exp_cmd[p]; tag = exp_tag[p]; exp_done = 1'b0;
        end else begin
            exp = NOP; tag = "R7"; exp_done = 1'b1;
        end
        check(tag, "command", act, exp);
        check("R7", "init_done", done0, exp_done);
        check("R2", "cke", cke0, 1);
        check("R8", "dqm", dqm0, exp_done ? 0 : 4'hF);
        if (exp == PRE) check("R3", "addr all-banks bit", addr0[APB], 1);
        if (exp == MRS) begin
            check("R4", "addr mode word", addr0, mode_word);
            check("R4", "bank", ba0, 0);
        end
        // R10: a command never repeats in the next cycle; the schedule only has single command slots
    endtask

    task automatic check_reset_state();
        check("R9", "reset command", {cs0, ras0, cas0, we0}, NOP);
        check("R9", "reset done", done0, 0);
        check("R9", "reset dqm", dqm0, 4'hF);
        check("R9", "reset cke", cke0, 1);
    endtask

    // Runs the schedule from reset release; stop_p < 0 means run past done
    task automatic run_seq(input logic [AW-1:0] mw, input int stop_p, input logic watch_u1);
        int last;
        int u1_refs;
        int u1_done_p;
        u1_refs = 0;
        u1_done_p = -1;
        mode_word = mw;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        last = (stop_p < 0) ? exp_cmd.size() + 6 : stop_p;
        for (int p = 0; p < last; p++) begin
            check_cycle(p);
            if (watch_u1) begin
                if ({cs1, ras1, cas1, we1} == REF) u1_refs++;
                if (done1 && u1_done_p < 0) u1_done_p = p;
            end
            @(negedge clk);
        end
        if (watch_u1) begin
            check("R6", "refresh count raised to 8", u1_refs, 8);
            check("R6", "done cycle with raised count", u1_done_p, exp_cmd.size());
        end
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset_state();
    endtask

    initial begin
        build_model();
        repeat (3) @(negedge clk);
        check_reset_state();
        run_seq(11'h032, -1, 1'b1);
        run_seq(11'h5A7, 70, 1'b0);
        run_seq(11'h0B8, -1, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule